// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog counter of the sort placed in a system I/O hub. Software programs a 10-bit start value, releases a halt control, and must then keep writing a reload register before the count runs out. The count steps down once for each pulse on a periodic tick enable, which comes from a divider outside the block and is nominally 0.6 s apart.

Running out of count is handled in two stages. On the first expiry the block raises a first-stage status flag and restarts from the programmed start value. If it expires again while that flag is still set, it raises a second-stage flag and a boot flag and sends a one-cycle reset request, unless a no-reboot control bit is set. A no-reboot bit blocks only the request: the flags still update. After the second expiry the count stays at zero until it is reloaded. Every status flag is cleared by writing a 1 to it.

Software reaches the block through a 16-bit register port with a write strobe, a read strobe and a 5-bit byte offset. Read data is registered.

Top module: `wdt2_hub`

## Requirements
- R1: After reset the count and the start value both equal RESET_LOAD (default 4). The halt bit is 1. The no-reboot bit and all status flags are 0. `reset_req` is low, and the read data is 0.
- R2: While the halt bit is 0, each cycle with `tick` high and a nonzero count lowers the count by exactly one. Cycles without `tick` leave it unchanged.
- R3: Bit 11 of the control register at offset 0x08 is the halt bit and reads back as written. While it is 1, ticks do not change the count.
- R4: A write of any data to offset 0x00 loads the count from the start value on the next clock edge. A read of offset 0x00 returns the count in bits 9:0 and zeros in bits 15:10.
- R5: The start-value register at offset 0x12 keeps the start value in bits 9:0 and stores bits 15:10 as plain data. A read returns all 16 bits as last accepted, and the full value 0x3FF is accepted.
- R6: A write to offset 0x12 whose bits 9:0 are below MIN_LOAD (default 4) is dropped completely, and the register keeps its earlier contents. A value equal to MIN_LOAD is accepted.
- R7: A tick that arrives while the counter runs at count 0 and bit 3 of the status register at offset 0x04 is clear is a first expiry. It sets that bit, reloads the count from the start value, and leaves `reset_req` low.
- R8: A tick that arrives while the counter runs at count 0 and bit 3 of offset 0x04 is set is a second expiry. It sets bit 1 (second stage) and bit 2 (boot) of the status register at offset 0x06 and drives `reset_req` high for exactly one cycle. The count then stays at 0 through further ticks until offset 0x00 is written.
- R9: If bit 3 of offset 0x04 is cleared between expiries, the next expiry is handled as a first expiry and produces no reset request.
- R10: Bit 1 of offset 0x08 is the no-reboot bit and reads back as written. While it is 1, a second expiry sets the status flags as in R8 but leaves `reset_req` low.
- R11: Each status flag is cleared by writing 1 to its bit position. Writing 0 to a flag bit has no effect, and clearing one flag leaves the others as they were.
- R12: Read data appears on `bus_rdata` in the cycle after the one in which `bus_re` is high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one per timer period |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| reset_req | output | 1 | One-cycle platform reset request |

## Verification
The bench uses the default parameters: a 10-bit count, RESET_LOAD of 4 and MIN_LOAD of 4. The tick is driven directly from the bench. Small start values such as 6 bring whole first-stage and second-stage sequences, with clears and the no-reboot mask, within a few dozen ticks. The full-scale value 0x3FF and the minimum legal value 4 are checked through register readback, and the values just below the minimum are checked to be rejected.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int FIRST_BIT   = 3;
  localparam int SECOND_BIT  = 1;
  localparam int BOOT_BIT    = 2;
  localparam int HALT_BIT    = 11;
  localparam int NOREBOOT_BIT = 1;

  typedef struct packed {
    logic halt;
    logic no_reboot;
  } ctrl_t;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } flags_t;
endpackage

// File: rtl/wdt2_regfile.sv
module wdt2_regfile
  import wdt2_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int RESET_LOAD = 4,
  parameter int MIN_LOAD   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  flags_t            flags,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  init_val,
  output ctrl_t             ctrl,
  output logic              reload_req,
  output logic              clr_first,
  output logic              clr_second,
  output logic              clr_boot
);
  localparam int SPARE_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] LOAD_MIN = CNT_W'(MIN_LOAD);
  localparam logic [CNT_W-1:0] LOAD_RST = CNT_W'(RESET_LOAD);

  logic [SPARE_W-1:0] spare_q;
  logic               wr_init, wr_ctrl, wr_st1, wr_st2, load_ok;
  logic [DATA_W-1:0]  rd_next;

  always_comb begin
    reload_req = bus_we && (bus_addr == OFS_RELOAD);
    wr_st1     = bus_we && (bus_addr == OFS_STAT1);
    wr_st2     = bus_we && (bus_addr == OFS_STAT2);
    wr_ctrl    = bus_we && (bus_addr == OFS_CTRL);
    wr_init    = bus_we && (bus_addr == OFS_INIT);
    load_ok    = bus_wdata[CNT_W-1:0] >= LOAD_MIN;
    clr_first  = wr_st1 && bus_wdata[FIRST_BIT];
    clr_second = wr_st2 && bus_wdata[SECOND_BIT];
    clr_boot   = wr_st2 && bus_wdata[BOOT_BIT];
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      OFS_RELOAD: rd_next[CNT_W-1:0] = count;
      OFS_STAT1:  rd_next[FIRST_BIT] = flags.first;
      OFS_STAT2: begin
        rd_next[SECOND_BIT] = flags.second;
        rd_next[BOOT_BIT]   = flags.boot;
      end
      OFS_CTRL: begin
        rd_next[HALT_BIT]     = ctrl.halt;
        rd_next[NOREBOOT_BIT] = ctrl.no_reboot;
      end
      OFS_INIT:   rd_next = {spare_q, init_val};
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_val       <= LOAD_RST;
      spare_q        <= '0;
      ctrl.halt      <= 1'b1;
      ctrl.no_reboot <= 1'b0;
      rd_data        <= '0;
    end else begin
      if (wr_init && load_ok) begin
        init_val <= bus_wdata[CNT_W-1:0];
        spare_q  <= bus_wdata[DATA_W-1:CNT_W];
      end
      if (wr_ctrl) begin
        ctrl.halt      <= bus_wdata[HALT_BIT];
        ctrl.no_reboot <= bus_wdata[NOREBOOT_BIT];
      end
      if (bus_re) rd_data <= rd_next;
    end
  end

  // R6: a rejected start value leaves the stored field untouched
  assert_reject_low_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_init && !load_ok) |=> ($stable(init_val) && $stable(spare_q)));

  // R12: read data only moves on a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(rd_data));
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int CNT_W      = 10,
  parameter int RESET_LOAD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] init_val,
  input  logic             first_set,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LOAD_RST = CNT_W'(RESET_LOAD);

  logic stuck;
  logic step;

  always_comb begin
    step   = tick && !halt && !stuck && !reload_req;
    expire = step && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= LOAD_RST;
      stuck <= 1'b0;
    end else if (reload_req) begin
      count <= init_val;
      stuck <= 1'b0;
    end else if (expire) begin
      if (first_set) stuck <= 1'b1;
      else           count <= init_val;
    end else if (step) begin
      count <= count - 1'b1;
    end
  end

  // R3: halted counter does not move except through a reload
  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload_req) |=> $stable(count));

  // R4: reload takes the start value
  assert_reload_value_R4: assert property (@(posedge clk) disable iff (rst)
    reload_req |=> (count == $past(init_val)));

  // R2: one step down per tick while running
  assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !halt && !reload_req && count != '0) |=>
      (count == CNT_W'($past(count) - 1'b1)));

  // R8: after the final expiry the count sits at zero
  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (rst)
    stuck |-> (count == '0));
endmodule

// File: rtl/wdt2_status.sv
module wdt2_status
  import wdt2_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   expire,
  input  logic   no_reboot,
  input  logic   clr_first,
  input  logic   clr_second,
  input  logic   clr_boot,
  output flags_t flags,
  output logic   rst_pulse
);
  logic final_hit;

  always_comb final_hit = expire && flags.first;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= final_hit && !no_reboot;

      if (expire && !flags.first) flags.first <= 1'b1;
      else if (clr_first)         flags.first <= 1'b0;

      if (final_hit)       flags.second <= 1'b1;
      else if (clr_second) flags.second <= 1'b0;

      if (final_hit)     flags.boot <= 1'b1;
      else if (clr_boot) flags.boot <= 1'b0;
    end
  end

  // R8: reset request lasts a single cycle
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  // R8: flags accompany the reset request
  assert_flags_with_req_R8: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> (flags.second && flags.boot));

  // R10: masked request never leaves the block
  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    no_reboot |=> !rst_pulse);

  // R7: a first expiry raises the first-stage flag
  assert_first_set_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && !flags.first) |=> flags.first);
endmodule

// File: rtl/wdt2_hub.sv
module wdt2_hub
  import wdt2_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int RESET_LOAD = 4,
  parameter int MIN_LOAD   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  logic [CNT_W-1:0] count, init_val;
  ctrl_t            ctrl;
  flags_t           flags;
  logic             reload_req, clr_first, clr_second, clr_boot, expire;

  wdt2_regfile #(
    .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD), .MIN_LOAD(MIN_LOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
    .flags(flags), .rd_data(bus_rdata), .init_val(init_val), .ctrl(ctrl),
    .reload_req(reload_req), .clr_first(clr_first),
    .clr_second(clr_second), .clr_boot(clr_boot)
  );

  wdt2_counter #(
    .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .halt(ctrl.halt),
    .reload_req(reload_req), .init_val(init_val), .first_set(flags.first),
    .count(count), .expire(expire)
  );

  wdt2_status u_stat (
    .clk(clk), .rst(rst), .expire(expire), .no_reboot(ctrl.no_reboot),
    .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
    .flags(flags), .rst_pulse(reset_req)
  );

  // R1: nothing requested straight out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !reset_req);
endmodule

// File: tb/wdt2_hub_test.sv
module wdt2_hub_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick = 0, bus_we = 0, bus_re = 0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        reset_req;

  int total = 0, bad = 0;
  int req_cycles = 0;
  bit finished = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  wdt2_hub uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  always @(negedge clk) if (!rst && reset_req) req_cycles++;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    check("R1 reset_req", {15'd0, reset_req}, 16'h0);
    rd(5'h00, rv); check("R1 count", rv, 16'h0004);
    rd(5'h08, rv); check("R1 ctrl", rv, 16'h0800);
    rd(5'h04, rv); check("R1 stat1", rv, 16'h0000);
    rd(5'h06, rv); check("R1 stat2", rv, 16'h0000);
    rd(5'h12, rv); check("R1 init", rv, 16'h0004);
  endtask

  task automatic t_init;
    wr(5'h12, 16'hA806);
    rd(5'h12, rv); check("R5 init readback", rv, 16'hA806);
    @(negedge clk); check("R12 data held", bus_rdata, 16'hA806);
    wr(5'h00, 16'h1234);
    rd(5'h00, rv); check("R4 reload", rv, 16'h0006);
    wr(5'h12, 16'hFC03);
    rd(5'h12, rv); check("R6 reject 3", rv, 16'hA806);
    wr(5'h12, 16'h0000);
    rd(5'h12, rv); check("R6 reject 0", rv, 16'hA806);
  endtask

  task automatic t_halt;
    ticks(3);
    rd(5'h00, rv); check("R3 frozen", rv, 16'h0006);
    wr(5'h08, 16'h0000);
    rd(5'h08, rv); check("R3 readback", rv, 16'h0000);
    ticks(2);
    rd(5'h00, rv); check("R2 two ticks", rv, 16'h0004);
    repeat (5) @(negedge clk);
    rd(5'h00, rv); check("R2 no tick", rv, 16'h0004);
    wr(5'h08, 16'h0800);
    ticks(2);
    rd(5'h00, rv); check("R3 halted again", rv, 16'h0004);
    wr(5'h08, 16'h0000);
  endtask

  task automatic t_first;
    ticks(4);
    rd(5'h00, rv); check("R2 at zero", rv, 16'h0000);
    ticks(1);
    rd(5'h04, rv); check("R7 first flag", rv, 16'h0008);
    rd(5'h00, rv); check("R7 reloaded", rv, 16'h0006);
    check("R7 no request", req_cycles[15:0], 16'd0);
  endtask

  task automatic t_clear_restart;
    wr(5'h04, 16'h0000);
    rd(5'h04, rv); check("R11 write 0 ignored", rv, 16'h0008);
    wr(5'h04, 16'h0008);
    rd(5'h04, rv); check("R11 cleared", rv, 16'h0000);
    ticks(7);
    rd(5'h04, rv); check("R9 first again", rv, 16'h0008);
    rd(5'h06, rv); check("R9 no second", rv, 16'h0000);
    check("R9 no request", req_cycles[15:0], 16'd0);
  endtask

  task automatic t_second;
    ticks(7);
    rd(5'h06, rv); check("R8 flags", rv, 16'h0006);
    check("R8 one cycle", req_cycles[15:0], 16'd1);
    rd(5'h00, rv); check("R8 count zero", rv, 16'h0000);
    ticks(3);
    rd(5'h00, rv); check("R8 holds zero", rv, 16'h0000);
    check("R8 no repeat", req_cycles[15:0], 16'd1);
    wr(5'h00, 16'h0000);
    rd(5'h00, rv); check("R8 reload frees", rv, 16'h0006);
  endtask

  task automatic t_mask;
    wr(5'h04, 16'h0008);
    wr(5'h06, 16'h0006);
    rd(5'h06, rv); check("R11 stat2 cleared", rv, 16'h0000);
    wr(5'h08, 16'h0002);
    rd(5'h08, rv); check("R10 readback", rv, 16'h0002);
    ticks(14);
    rd(5'h06, rv); check("R10 flags still set", rv, 16'h0006);
    check("R10 request masked", req_cycles[15:0], 16'd1);
    wr(5'h06, 16'h0002);
    rd(5'h06, rv); check("R11 only second cleared", rv, 16'h0004);
    rd(5'h04, rv); check("R11 stat1 untouched", rv, 16'h0008);
  endtask

  task automatic t_limits;
    wr(5'h12, 16'h03FF);
    wr(5'h00, 16'h0000);
    rd(5'h00, rv); check("R5 full scale", rv, 16'h03FF);
    wr(5'h12, 16'h0004);
    rd(5'h12, rv); check("R6 minimum accepted", rv, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_init();
    t_halt();
    t_first();
    t_clear_restart();
    t_second();
    t_mask();
    t_limits();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule